// File: doc/BRIEF.md
# Audio codec control register file

This block is the control and status register bank of an audio codec. A host reaches it through a simple synchronous port. The port carries a write strobe, a read strobe, a 7-bit register index and 16-bit data. Every register sits at an even index. Read data is registered and appears on the cycle after the read strobe. It then holds until the next read.

The bank stores two sample rates. Each rate is an unsigned count of hertz at 1 Hz resolution, and each drives an output port for the converter clocking logic. Each rate has a primary index and a second, alias index. The alias only works while a variable-rate enable bit in a control register is set. Writing a zero to that bit forces both rates back to 48000. The bank also returns two fixed identification words. Odd indices, unmapped indices and reserved bits are inert.

The supported rate range is 7000 to 48000 Hz. Values outside that range are stored as written. What the converters do with such values is not defined.

Top module: `codec_ctrl_regs`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both rates load 48000 (BB80h), the enable bit loads 0 and `rdata` loads 0000h.
- R2: Index 7Ah (rate A) and index 78h (rate B) are read/write 16-bit registers, readable and writable whatever the enable bit is. `rate_a_hz` and `rate_b_hz` show their values from the cycle after the write.
- R3: While the enable bit is 1, index 2Ch reads and writes the storage of rate A, and index 32h reads and writes the storage of rate B.
- R4: While the enable bit is 0, writes to 2Ch and 32h change nothing, and reads of them return BB80h.
- R5: Any write to index 2Ah with data bit 0 equal to 0 reloads both rates with BB80h, even when the enable bit was already 0.
- R6: Index 2Ah holds the enable bit in bit 0. Bits 15:1 of that index always read as 0.
- R7: A write to any odd index changes no register. A read of any odd index returns 0000h.
- R8: Index 7Ch always reads 4144h, and writes to it are ignored.
- R9: Index 7Eh always reads 5340h: an identification character 53h in the upper byte and revision 40h in the lower byte. Writes to it are ignored.
- R10: An even index outside the set {2Ah, 2Ch, 32h, 78h, 7Ah, 7Ch, 7Eh} reads 0000h, and a write to it changes nothing.
- R11: `rdata` is updated only on the cycle after `rd_en` is high and otherwise holds its value. When a read and a write target the same cycle, the read returns the value from before the write.
- R12: Rate values outside 7000..48000 (for example 0001h and FFFFh) are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the index on `addr` |
| rd_en | input | 1 | Read strobe; `rdata` updates one cycle later |
| addr | input | 7 | Register index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rate_a_hz | output | 16 | Current rate A in hertz |
| rate_b_hz | output | 16 | Current rate B in hertz |

## Verification
Rates are written through the primary and alias indices with the enable bit both clear and set. Each write uses a different value, so a read separates shared storage from a stale register and from the fixed 48000 that a locked alias returns.

The enable bit is cleared twice: once from set, and once when it is already clear after a primary write. This shows that the reload follows the written data bit and not an edge of the bit.

Odd, unmapped and read-only indices receive writes with data that would visibly alter a rate or the enable bit if the write leaked through. A read issued in the same cycle as a write, followed by a second read, separates pre-write from post-write read data.

// File: rtl/codec_regs_pkg.sv
// Package: shared sizes, register indices and constants of the codec
// control register file. Assumes every mapped index is even.
package codec_regs_pkg;

    localparam int CR_ADDR_W    = 7;
    localparam int CR_DATA_W    = 16;
    localparam int CR_NUM_RATES = 2;
    localparam int CR_EN_BIT    = 0;

    localparam logic [CR_DATA_W-1:0] CR_RATE_DEFAULT = 16'hBB80;

    localparam logic [CR_ADDR_W-1:0] CR_IDX_CTRL = 7'h2A;
    localparam logic [CR_ADDR_W-1:0] CR_IDX_VID1 = 7'h7C;
    localparam logic [CR_ADDR_W-1:0] CR_IDX_VID2 = 7'h7E;

    // entry 0 is rate A, entry 1 is rate B
    localparam logic [CR_ADDR_W-1:0] CR_RATE_PRI_IDX [CR_NUM_RATES] = '{7'h7A, 7'h78};
    localparam logic [CR_ADDR_W-1:0] CR_RATE_ALT_IDX [CR_NUM_RATES] = '{7'h2C, 7'h32};

    localparam logic [CR_DATA_W-1:0] CR_VID1_WORD = 16'h4144;
    localparam logic [7:0]           CR_VID2_CHAR = 8'h53;

    // one-hot-ish decode of the current index
    typedef struct packed {
        logic                    odd;
        logic                    ctrl;
        logic                    vid1;
        logic                    vid2;
        logic [CR_NUM_RATES-1:0] pri;
        logic [CR_NUM_RATES-1:0] alt;
    } cr_sel_t;

endpackage

// File: rtl/codec_addr_decode.sv
// Module: turns a register index into select flags.
// Assumes: purely combinational; an odd index selects nothing but the odd flag.
module codec_addr_decode
    import codec_regs_pkg::*;
(
    input  logic [CR_ADDR_W-1:0] addr,
    output cr_sel_t              sel
);

    // decode each mapped index, suppressed for odd indices
    always_comb begin
        sel      = '0;
        sel.odd  = addr[0];
        sel.ctrl = !addr[0] && (addr == CR_IDX_CTRL);
        sel.vid1 = !addr[0] && (addr == CR_IDX_VID1);
        sel.vid2 = !addr[0] && (addr == CR_IDX_VID2);
        for (int i = 0; i < CR_NUM_RATES; i++) begin
            sel.pri[i] = !addr[0] && (addr == CR_RATE_PRI_IDX[i]);
            sel.alt[i] = !addr[0] && (addr == CR_RATE_ALT_IDX[i]);
        end
    end

endmodule

// File: rtl/codec_rate_reg.sv
// Module: one sample-rate storage register.
// Assumes: reload and write are never both high; reload wins if they are.
module codec_rate_reg #(
    parameter int               DATA_W    = 16,
    parameter logic [DATA_W-1:0] RESET_VAL = 16'hBB80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    // hold, reload to default, or take new data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (reload) begin
            q <= RESET_VAL;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/codec_read_mux.sv
// Module: selects the read value for the decoded index.
// Assumes: sel comes from codec_addr_decode; unmatched or odd reads give zero.
module codec_read_mux
    import codec_regs_pkg::*;
#(
    parameter logic [7:0] REV_ID = 8'h40
) (
    input  cr_sel_t                               sel,
    input  logic                                  var_rate_en,
    input  logic [CR_NUM_RATES-1:0][CR_DATA_W-1:0] rates,
    output logic [CR_DATA_W-1:0]                  value
);

    // priority-free select: at most one flag of sel is set for an even index
    always_comb begin
        value = '0;
        if (!sel.odd) begin
            if (sel.ctrl) value = {{(CR_DATA_W-1){1'b0}}, var_rate_en};
            if (sel.vid1) value = CR_VID1_WORD;
            if (sel.vid2) value = {CR_VID2_CHAR, REV_ID};
            for (int i = 0; i < CR_NUM_RATES; i++) begin
                if (sel.pri[i]) value = rates[i];
                if (sel.alt[i]) value = var_rate_en ? rates[i] : CR_RATE_DEFAULT;
            end
        end
    end

endmodule

// File: rtl/codec_ctrl_regs.sv
// Module: top of the codec control register file.
// Holds the variable-rate enable bit and two rate registers, gates the
// alias indices with the enable bit, and registers read data.
// Assumes: one access index per cycle shared by read and write.
module codec_ctrl_regs
    import codec_regs_pkg::*;
#(
    parameter logic [7:0] REV_ID = 8'h40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [CR_ADDR_W-1:0] addr,
    input  logic [CR_DATA_W-1:0] wdata,
    output logic [CR_DATA_W-1:0] rdata,
    output logic [CR_DATA_W-1:0] rate_a_hz,
    output logic [CR_DATA_W-1:0] rate_b_hz
);

    cr_sel_t                               sel;
    logic                                  var_rate_en;
    logic                                  rate_reload;
    logic [CR_NUM_RATES-1:0]               rate_we;
    logic [CR_NUM_RATES-1:0][CR_DATA_W-1:0] rates;
    logic [CR_DATA_W-1:0]                  rd_value;

    codec_addr_decode u_dec (
        .addr (addr),
        .sel  (sel)
    );

    // a control write with a cleared enable bit reloads both rates
    assign rate_reload = wr_en && sel.ctrl && !wdata[CR_EN_BIT];

    // enable bit storage; other control bits are reserved
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            var_rate_en <= 1'b0;
        end else if (wr_en && sel.ctrl) begin
            var_rate_en <= wdata[CR_EN_BIT];
        end
    end

    genvar g;
    generate
        for (g = 0; g < CR_NUM_RATES; g++) begin : g_rate
            // primary index always writes; alias only while enabled
            assign rate_we[g] = wr_en && (sel.pri[g] || (sel.alt[g] && var_rate_en));

            codec_rate_reg #(
                .DATA_W    (CR_DATA_W),
                .RESET_VAL (CR_RATE_DEFAULT)
            ) u_rate (
                .clk    (clk),
                .rst_n  (rst_n),
                .reload (rate_reload),
                .we     (rate_we[g]),
                .wdata  (wdata),
                .q      (rates[g])
            );
        end
    endgenerate

    codec_read_mux #(
        .REV_ID (REV_ID)
    ) u_rmux (
        .sel         (sel),
        .var_rate_en (var_rate_en),
        .rates       (rates),
        .value       (rd_value)
    );

    // read data register, updated only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_value;
        end
    end

    assign rate_a_hz = rates[0];
    assign rate_b_hz = rates[1];

endmodule

// File: rtl/codec_ctrl_regs_chk.sv
// Module: assertion checker for codec_ctrl_regs, attached by bind.
module codec_ctrl_regs_chk
    import codec_regs_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [CR_ADDR_W-1:0] addr,
    input logic [CR_DATA_W-1:0] wdata,
    input logic [CR_DATA_W-1:0] rdata,
    input logic [CR_DATA_W-1:0] rate_a,
    input logic [CR_DATA_W-1:0] rate_b,
    input logic                 var_rate_en
);

    // R2
    pri_write_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 7'h7A) |=> (rate_a == $past(wdata)));

    // R4
    alt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 7'h2C && !var_rate_en) |=> $stable(rate_a));

    // R5
    en_clear_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 7'h2A && !wdata[0]) |=> (rate_a == 16'hBB80 && rate_b == 16'hBB80));

    // R7
    odd_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[0]) |=> ($stable(rate_a) && $stable(rate_b) && $stable(var_rate_en)));

    // R7
    odd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[0]) |=> (rdata == 16'h0000));

    // R8
    vid1_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 7'h7C) |=> (rdata == 16'h4144));

    // R9
    vid2_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 7'h7E) |=> (rdata == 16'h5340));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind codec_ctrl_regs codec_ctrl_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .rate_a      (rate_a_hz),
    .rate_b      (rate_b_hz),
    .var_rate_en (var_rate_en)
);

// File: tb/tb_codec_ctrl_regs.sv
// Directed bench for codec_ctrl_regs: one task per scenario.
module tb_codec_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, rate_a_hz, rate_b_hz;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    codec_ctrl_regs dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .rate_a_hz (rate_a_hz),
        .rate_b_hz (rate_b_hz)
    );

    always #2 clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 rdata", rdata, 16'h0000);
        check("R1 rate_a", rate_a_hz, 16'hBB80);
        check("R1 rate_b", rate_b_hz, 16'hBB80);
        rd_chk("R1 ctrl", 7'h2A, 16'h0000);
    endtask

    task automatic t_primary();
        wr(7'h7A, 16'h1F40);
        check("R2 rate_a out", rate_a_hz, 16'h1F40);
        rd_chk("R2 read 7A", 7'h7A, 16'h1F40);
        wr(7'h78, 16'hAC44);
        check("R2 rate_b out", rate_b_hz, 16'hAC44);
        check("R2 rate_a kept", rate_a_hz, 16'h1F40);
        rd_chk("R2 read 78", 7'h78, 16'hAC44);
    endtask

    task automatic t_alias_locked();
        wr(7'h2C, 16'h2EE0);
        check("R4 rate_a kept", rate_a_hz, 16'h1F40);
        rd_chk("R4 read 2C", 7'h2C, 16'hBB80);
        wr(7'h32, 16'h1234);
        check("R4 rate_b kept", rate_b_hz, 16'hAC44);
        rd_chk("R4 read 32", 7'h32, 16'hBB80);
    endtask

    task automatic t_ctrl_bits();
        wr(7'h2A, 16'hFFFF);
        rd_chk("R6 ctrl reserved", 7'h2A, 16'h0001);
        check("R6 rate_a no reload", rate_a_hz, 16'h1F40);
    endtask

    task automatic t_alias_open();
        wr(7'h2C, 16'h5622);
        check("R3 rate_a via 2C", rate_a_hz, 16'h5622);
        rd_chk("R3 read 7A", 7'h7A, 16'h5622);
        rd_chk("R3 read 2C", 7'h2C, 16'h5622);
        wr(7'h78, 16'h3E80);
        rd_chk("R3 read 32", 7'h32, 16'h3E80);
        wr(7'h32, 16'h2B11);
        check("R3 rate_b via 32", rate_b_hz, 16'h2B11);
    endtask

    task automatic t_range();
        wr(7'h7A, 16'h0001);
        rd_chk("R12 low", 7'h7A, 16'h0001);
        wr(7'h78, 16'hFFFF);
        rd_chk("R12 high", 7'h78, 16'hFFFF);
    endtask

    task automatic t_clear();
        wr(7'h2A, 16'hFFFE);
        check("R5 rate_a", rate_a_hz, 16'hBB80);
        check("R5 rate_b", rate_b_hz, 16'hBB80);
        rd_chk("R5 ctrl", 7'h2A, 16'h0000);
        wr(7'h7A, 16'h1B58);
        wr(7'h2A, 16'h0000);
        check("R5 reload when off", rate_a_hz, 16'hBB80);
    endtask

    task automatic t_odd();
        wr(7'h7B, 16'h1111);
        wr(7'h79, 16'h2222);
        wr(7'h2B, 16'h0001);
        wr(7'h2D, 16'h3333);
        check("R7 rate_a", rate_a_hz, 16'hBB80);
        check("R7 rate_b", rate_b_hz, 16'hBB80);
        rd_chk("R7 ctrl", 7'h2A, 16'h0000);
        rd_chk("R7 read 7B", 7'h7B, 16'h0000);
        rd_chk("R7 read 7D", 7'h7D, 16'h0000);
        rd_chk("R7 read 01", 7'h01, 16'h0000);
    endtask

    task automatic t_ids();
        rd_chk("R8 7C", 7'h7C, 16'h4144);
        wr(7'h7C, 16'h0000);
        rd_chk("R8 7C after write", 7'h7C, 16'h4144);
        rd_chk("R9 7E", 7'h7E, 16'h5340);
        wr(7'h7E, 16'hFFFF);
        rd_chk("R9 7E after write", 7'h7E, 16'h5340);
    endtask

    task automatic t_unmapped();
        wr(7'h00, 16'hABCD);
        wr(7'h40, 16'h0001);
        rd_chk("R10 read 00", 7'h00, 16'h0000);
        rd_chk("R10 read 40", 7'h40, 16'h0000);
        check("R10 rate_a", rate_a_hz, 16'hBB80);
        rd_chk("R10 ctrl", 7'h2A, 16'h0000);
    endtask

    task automatic t_timing();
        wr(7'h7A, 16'h2B11);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 7'h7A; wdata = 16'h3E80;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R11 read before write", rdata, 16'h2B11);
        addr = 7'h7C;
        repeat (3) @(negedge clk);
        check("R11 hold", rdata, 16'h2B11);
        rd_chk("R11 read after write", 7'h7A, 16'h3E80);
    endtask

    task automatic t_reset_mid();
        wr(7'h2A, 16'h0001);
        wr(7'h78, 16'h1B58);
        do_reset();
        check("R1 mid rate_b", rate_b_hz, 16'hBB80);
        check("R1 mid rate_a", rate_a_hz, 16'hBB80);
        rd_chk("R1 mid ctrl", 7'h2A, 16'h0000);
        rd_chk("R1 mid alias", 7'h2C, 16'hBB80);
    endtask

    initial begin
        t_reset();
        t_primary();
        t_alias_locked();
        t_ctrl_bits();
        t_alias_open();
        t_range();
        t_clear();
        t_odd();
        t_ids();
        t_unmapped();
        t_timing();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule